// File: doc/BRIEF.md
# Dual Wiper Position and Stored Setting Bank

This block holds the settings of two digitally controlled potentiometers. Each pot has a volatile wiper position register, which drives the tap selection, and four stored setting registers. The stored settings stand in for nonvolatile cells: they keep their contents across the modelled reset. A serial front end decodes host commands and hands them to the block as a single-cycle strobe. Each strobe carries an opcode, a pot index, a register index and a data byte.

The block executes the command in the cycle it is strobed. The commands are direct reads and writes of either register kind, copies between a pot's wiper and one of its stored settings, and broadcast copies that act on both pots at once. Any command that changes a stored setting opens a timed busy window, and the busy flag is high for that whole window. A protect input, when low, blocks every change to stored settings. When reset is released, each wiper reloads from its own setting 0.

Top module: `potbank_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy` and `rd_valid` are 0. Each wiper equals its stored setting 0. At first power-up every stored setting holds `INIT_VAL` (0x80 by default).
- R2: Opcode 1 (wiper write) loads `cmd_data` into the wiper that `cmd_pot` selects, visible one cycle after the strobe. The other wiper is unchanged and `busy` is not set.
- R3: Opcode 3 (setting write) stores `cmd_data` into setting `cmd_reg` of pot `cmd_pot`. `cmd_reg` values 0, 1, 2 and 3 select settings 0 to 3.
- R4: Opcode 0 (wiper read) and opcode 2 (setting read) raise `rd_valid` for exactly one cycle, one cycle after the strobe. `rd_data` then holds the selected wiper, or setting `cmd_reg` of pot `cmd_pot`.
- R5: Opcode 4 (single load) copies setting `cmd_reg` of pot `cmd_pot` into that pot's wiper on the next cycle. The other wiper is unchanged and `busy` is not set.
- R6: Opcode 5 (single store) copies the wiper of pot `cmd_pot` into its setting `cmd_reg`. The other pot's settings are unchanged.
- R7: Opcode 6 (broadcast load) copies setting `cmd_reg` of every pot into that pot's own wiper, whatever the value of `cmd_pot`.
- R8: Opcode 7 (broadcast store) copies every pot's wiper into its own setting `cmd_reg`.
- R9: An accepted command with opcode 3, 5 or 7 raises `busy` on the next cycle. `busy` then stays high for exactly `WR_CYCLES` consecutive cycles. No other command raises `busy`.
- R10: While `store_allow` is 0, opcodes 3, 5 and 7 change no stored setting and leave `busy` at 0. Wiper commands still take effect.
- R11: While `busy` is 1, opcodes 3, 5 and 7 are rejected. The settings stay as they are and the busy window is not extended. Wiper writes and reads are still accepted.
- R12: Stored settings keep their values across `rst`. The reload after reset uses the latest value of setting 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads wipers from setting 0 |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 3 | Opcode 0..7 as listed in the requirements |
| cmd_pot | input | 1 | Pot index |
| cmd_reg | input | 2 | Stored setting index |
| cmd_data | input | 8 | Write data |
| store_allow | input | 1 | Low blocks every change to stored settings |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 8 | Read data |
| wiper_pos | output | 16 | Wiper positions, pot 0 in bits 7:0, pot 1 in bits 15:8 |
| busy | output | 1 | Stored-setting write in progress |

## Verification
The bench sweeps all 256 wiper codes on each pot and checks that the other wiper never moves. A decode that used the wrong pot bit would show up here. It also writes every setting with a distinct value and loads each one back, which exposes a swapped register index or a broadcast that ignores one pot. The busy window is measured cycle by cycle, so a counter that is off by one gives the wrong length. A second write is issued in the middle of a window: a design that accepts it, or restarts the timer, leaves the wrong value or a longer window. Protected writes are checked by reading the setting back, and the reset reload is checked after setting 0 has been rewritten, so a design that reloads a constant instead of the setting fails.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
  typedef enum logic [2:0] {
    OP_RD_WIPER  = 3'd0,
    OP_WR_WIPER  = 3'd1,
    OP_RD_REG    = 3'd2,
    OP_WR_REG    = 3'd3,
    OP_LOAD_ONE  = 3'd4,
    OP_STORE_ONE = 3'd5,
    OP_LOAD_ALL  = 3'd6,
    OP_STORE_ALL = 3'd7
  } pb_op_e;
endpackage

// File: rtl/potbank_nvstore.sv
// Stored settings of one pot: small distributed memory, no reset.
module potbank_nvstore #(
  parameter int N_REGS = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] INIT_VAL = 'h80,
  localparam int RW = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] rdata0
);
  logic [DW-1:0] mem [N_REGS] = '{default: INIT_VAL};

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata  = mem[addr];
  assign rdata0 = mem[0];
endmodule

// File: rtl/potbank_wiper.sv
// Volatile wiper position register of one pot, reloaded during reset.
module potbank_wiper #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] recall_val,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst)     pos <= recall_val;
    else if (ld) pos <= ld_val;
  end
endmodule

// File: rtl/potbank_busytimer.sv
// Busy window: high for exactly WR_CYCLES cycles after a start pulse.
module potbank_busytimer #(
  parameter int WR_CYCLES = 40,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= CW'(WR_CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/potbank_core.sv
module potbank_core
  import potbank_pkg::*;
#(
  parameter int N_POTS = 2,
  parameter int N_REGS = 4,
  parameter int DW = 8,
  parameter int WR_CYCLES = 40,
  parameter logic [DW-1:0] INIT_VAL = 'h80,
  localparam int PW = (N_POTS > 1) ? $clog2(N_POTS) : 1,
  localparam int RW = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [PW-1:0]        cmd_pot,
  input  logic [RW-1:0]        cmd_reg,
  input  logic [DW-1:0]        cmd_data,
  input  logic                 store_allow,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data,
  output logic [N_POTS*DW-1:0] wiper_pos,
  output logic                 busy
);
  pb_op_e op;
  logic   modifies;
  logic   nv_go;
  logic   is_read;

  logic [DW-1:0] wcr     [N_POTS];
  logic [DW-1:0] dr_sel  [N_POTS];
  logic [DW-1:0] dr_zero [N_POTS];

  assign op = pb_op_e'(cmd_op);

  always_comb begin
    modifies = cmd_valid && !rst &&
               (op == OP_WR_REG || op == OP_STORE_ONE || op == OP_STORE_ALL);
    is_read  = cmd_valid && (op == OP_RD_WIPER || op == OP_RD_REG);
  end

  // R10/R11: protect input and busy window gate every stored-setting change
  assign nv_go = modifies && store_allow && !busy;

  for (genvar p = 0; p < N_POTS; p++) begin : g_pot
    logic          hit;
    logic          we;
    logic [DW-1:0] wdata;
    logic          ld;
    logic [DW-1:0] ld_val;

    always_comb begin
      hit    = (cmd_pot == PW'(p));
      we     = nv_go && (op == OP_STORE_ALL || hit);
      wdata  = (op == OP_WR_REG) ? cmd_data : wcr[p];
      ld     = cmd_valid && ((hit && (op == OP_WR_WIPER || op == OP_LOAD_ONE)) ||
                             op == OP_LOAD_ALL);
      ld_val = (op == OP_WR_WIPER) ? cmd_data : dr_sel[p];
    end

    potbank_nvstore #(.N_REGS(N_REGS), .DW(DW), .INIT_VAL(INIT_VAL)) u_store (
      .clk    (clk),
      .we     (we),
      .addr   (cmd_reg),
      .wdata  (wdata),
      .rdata  (dr_sel[p]),
      .rdata0 (dr_zero[p])
    );

    potbank_wiper #(.DW(DW)) u_wiper (
      .clk        (clk),
      .rst        (rst),
      .recall_val (dr_zero[p]),
      .ld         (ld),
      .ld_val     (ld_val),
      .pos        (wcr[p])
    );

    assign wiper_pos[p*DW +: DW] = wcr[p];
  end

  potbank_busytimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (nv_go),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= is_read;
      if (is_read)
        rd_data <= (op == OP_RD_WIPER) ? wcr[cmd_pot] : dr_sel[cmd_pot];
    end
  end
endmodule

// File: rtl/potbank_checker.sv
module potbank_checker #(
  parameter int N_POTS = 2,
  parameter int DW = 8,
  parameter int WR_CYCLES = 40,
  localparam int PW = (N_POTS > 1) ? $clog2(N_POTS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_op,
  input logic [PW-1:0]        cmd_pot,
  input logic [DW-1:0]        cmd_data,
  input logic                 store_allow,
  input logic                 rd_valid,
  input logic [N_POTS*DW-1:0] wiper_pos,
  input logic                 busy
);
  int run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  logic rd_cmd, mod_cmd, wr_w0, load_cmd;
  always_comb begin
    rd_cmd   = cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd2);
    mod_cmd  = cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd5 || cmd_op == 3'd7);
    wr_w0    = cmd_valid && cmd_op == 3'd1 && cmd_pot == '0;
    load_cmd = cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd6);
  end

  a_r4_read_valid: assert property (@(posedge clk) disable iff (rst)
    rd_cmd |=> rd_valid);
  a_r4_valid_cause: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_cmd));
  a_r2_wiper_write: assert property (@(posedge clk) disable iff (rst)
    wr_w0 |=> (wiper_pos[DW-1:0] == $past(cmd_data)));
  a_r2_other_pot: assert property (@(posedge clk) disable iff (rst)
    wr_w0 |=> $stable(wiper_pos[N_POTS*DW-1:DW]));
  a_r9_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(mod_cmd && store_allow));
  a_r9_busy_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < WR_CYCLES));
  a_r9_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == WR_CYCLES));
  a_r10_protect: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !store_allow && !busy) |=> !busy);
  a_r5_load_no_busy: assert property (@(posedge clk) disable iff (rst)
    (load_cmd && !busy) |=> !busy);
endmodule

bind potbank_core potbank_checker #(
  .N_POTS(N_POTS), .DW(DW), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_pot(cmd_pot), .cmd_data(cmd_data), .store_allow(store_allow),
  .rd_valid(rd_valid), .wiper_pos(wiper_pos), .busy(busy)
);

// File: tb/sim_potbank_core.sv
module sim_potbank_core;
  localparam int WR = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        cmd_pot = 1'b0;
  logic [1:0]  cmd_reg = '0;
  logic [7:0]  cmd_data = '0;
  logic        store_allow = 1'b1;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [15:0] wiper_pos;
  logic        busy;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_dr [2][4];
  logic [7:0] exp_w [2];

  always #2 clk = ~clk;

  potbank_core #(.WR_CYCLES(WR)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .store_allow(store_allow), .rd_valid(rd_valid), .rd_data(rd_data),
    .wiper_pos(wiper_pos), .busy(busy)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic p, input logic [1:0] r,
                       input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pot = p; cmd_reg = r; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_reg(input string req, input logic p, input logic [1:0] r);
    issue(3'd2, p, r, 8'h00);
    check(req, {7'd0, rd_valid, rd_data}, {8'h01, exp_dr[p][r]});
  endtask

  task automatic check_wipers(input string req);
    check(req, wiper_pos, {exp_w[1], exp_w[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    for (int p = 0; p < 2; p++) begin
      exp_w[p] = 8'h80;
      for (int r = 0; r < 4; r++) exp_dr[p][r] = 8'h80;
    end
    repeat (4) @(negedge clk);
    check("R1 busy in reset", {15'd0, busy}, 16'd0);
    rst = 1'b0;
    check("R1 reset state", {busy, rd_valid, 6'd0, 8'd0}, 16'd0);
    check_wipers("R1 initial recall");
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) read_reg("R1 initial setting", p[0], r[1:0]);

    // R2 + R4: exhaustive wiper code sweep on each pot
    for (int p = 0; p < 2; p++)
      for (int v = 0; v < 256; v++) begin
        issue(3'd1, p[0], 2'd0, v[7:0]);
        exp_w[p] = v[7:0];
        check_wipers("R2 wiper write");
        check("R2 no busy", {15'd0, busy}, 16'd0);
        issue(3'd0, p[0], 2'd0, 8'h00);
        check("R4 wiper read", {7'd0, rd_valid, rd_data}, {8'h01, v[7:0]});
      end
    @(negedge clk);
    check("R4 valid one cycle", {15'd0, rd_valid}, 16'd0);

    // R3 + R9: write every setting, measure busy window
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] v;
        v = 8'(p * 64 + r * 17 + 5);
        issue(3'd3, p[0], r[1:0], v);
        exp_dr[p][r] = v;
        busy_len(n);
        check("R9 busy window", 16'(n), 16'(WR));
        read_reg("R3 setting write", p[0], r[1:0]);
      end

    // R10: protect low
    store_allow = 1'b0;
    issue(3'd3, 1'b0, 2'd1, 8'h5A);
    check("R10 no busy", {15'd0, busy}, 16'd0);
    read_reg("R10 setting unchanged", 1'b0, 2'd1);
    issue(3'd7, 1'b1, 2'd2, 8'h00);
    check("R10 no busy bcast", {15'd0, busy}, 16'd0);
    read_reg("R10 bcast p0", 1'b0, 2'd2);
    read_reg("R10 bcast p1", 1'b1, 2'd2);
    issue(3'd1, 1'b1, 2'd0, 8'hA7);
    exp_w[1] = 8'hA7;
    check_wipers("R10 wiper still works");
    store_allow = 1'b1;

    // R5: single load of every setting
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) begin
        issue(3'd4, p[0], r[1:0], 8'h00);
        exp_w[p] = exp_dr[p][r];
        check_wipers("R5 single load");
        check("R5 no busy", {15'd0, busy}, 16'd0);
      end

    // R7: broadcast load, pot field ignored
    for (int r = 0; r < 4; r++) begin
      issue(3'd6, r[0], r[1:0], 8'h00);
      exp_w[0] = exp_dr[0][r];
      exp_w[1] = exp_dr[1][r];
      check_wipers("R7 broadcast load");
    end

    // R6: single store
    issue(3'd1, 1'b1, 2'd0, 8'h3C);
    exp_w[1] = 8'h3C;
    issue(3'd5, 1'b1, 2'd3, 8'h00);
    exp_dr[1][3] = 8'h3C;
    busy_len(n);
    check("R9 store window", 16'(n), 16'(WR));
    read_reg("R6 single store", 1'b1, 2'd3);
    read_reg("R6 other pot untouched", 1'b0, 2'd3);

    // R8: broadcast store into setting 0
    issue(3'd1, 1'b0, 2'd0, 8'h11);
    issue(3'd1, 1'b1, 2'd0, 8'hEE);
    exp_w[0] = 8'h11; exp_w[1] = 8'hEE;
    issue(3'd7, 1'b0, 2'd0, 8'h00);
    exp_dr[0][0] = 8'h11; exp_dr[1][0] = 8'hEE;
    busy_len(n);
    check("R8 bcast window", 16'(n), 16'(WR));
    read_reg("R8 bcast p0", 1'b0, 2'd0);
    read_reg("R8 bcast p1", 1'b1, 2'd0);

    // R11: second write during busy is rejected, window not extended
    issue(3'd3, 1'b0, 2'd2, 8'h77);
    exp_dr[0][2] = 8'h77;
    check("R11 busy set", {15'd0, busy}, 16'd1);
    issue(3'd3, 1'b0, 2'd2, 8'h99);
    busy_len(n);
    check("R11 window not extended", 16'(n + 2), 16'(WR));
    read_reg("R11 rejected write", 1'b0, 2'd2);
    issue(3'd3, 1'b1, 2'd1, 8'h42);
    exp_dr[1][1] = 8'h42;
    issue(3'd1, 1'b0, 2'd0, 8'h24);
    exp_w[0] = 8'h24;
    check_wipers("R11 wiper write while busy");
    issue(3'd5, 1'b0, 2'd1, 8'h00);
    busy_len(n);
    read_reg("R11 store rejected", 1'b0, 2'd1);
    read_reg("R11 first write kept", 1'b1, 2'd1);

    // R12: settings survive reset, reload uses latest setting 0
    issue(3'd1, 1'b0, 2'd0, 8'h00);
    issue(3'd1, 1'b1, 2'd0, 8'h00);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_w[0] = exp_dr[0][0]; exp_w[1] = exp_dr[1][0];
    check_wipers("R12 recall latest setting 0");
    check("R1 reset clears flags", {14'd0, busy, rd_valid}, 16'd0);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) read_reg("R12 settings kept", p[0], r[1:0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule